// File: doc/BRIEF.md
# Reset Time-Out Sequencer

This block keeps a processor core in reset after a reset event until up to two timed waits have run out. The first wait is a fixed-length power-up delay counted in ticks of a slow timebase; the second is an oscillator start-up delay that counts a fixed number of cycles of the clock the block runs on. The oscillator mode and a configuration bit decide which waits apply. The power-on pulse clears the sequencer asynchronously. A brown-out detect restarts it at any time.

The external active-low master clear reaches the core reset through a two-flop synchronizer. It does not touch the timers. If master clear is held low for longer than the waits, the core starts running as soon as master clear is released, apart from the synchronizer latency. A wake-up request from sleep runs only the oscillator start-up wait, and only in crystal modes. During that wait the run enable is low but the core reset stays low, so the core keeps its state.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_pulse_i` or `brownout_i` is high, `core_rst_o` is 1 and `run_en_o` is 0.
- R2: Setup for R2 to R4: `slow_tick_i` is high on every cycle and master clear is high, with `osc_rc_i`=0 (crystal), `pwrt_skip_i`=0 (power-up wait active). `core_rst_o` then falls on clock edge 1+PWRT_TICKS+OST_CYCLES, where edge 1 is the first edge that samples the power-on pulse low.
- R3: With `osc_rc_i`=1 (RC) and `pwrt_skip_i`=0, the start-up count is skipped and `core_rst_o` falls on edge 1+PWRT_TICKS.
- R4: With `pwrt_skip_i`=1 the power-up wait is skipped after a power-on pulse. In crystal mode `core_rst_o` falls on edge 1+OST_CYCLES. In RC mode there is no time-out: only the two-flop master-clear latency remains, so it falls on edge 2.
- R5: The power-up wait advances only on cycles where `slow_tick_i` is high. With the tick held at 0, `core_rst_o` stays high for as long as it is held.
- R6: After a brown-out ends, the power-up wait always runs, whatever `pwrt_skip_i` is. Crystal mode then adds the start-up count, so it falls on edge 1+PWRT_TICKS+OST_CYCLES. RC mode falls on edge 1+PWRT_TICKS.
- R7: A brown-out while a sequence is running restarts it from the power-up wait. The full delay of R6 is counted again from the release of the brown-out.
- R8: While running in crystal mode, a one-cycle `wake_req_i` drops `run_en_o` for exactly OST_CYCLES samples and keeps `core_rst_o` at 0. In RC mode a wake request has no effect on either output.
- R9: `mclr_n_i` low raises `core_rst_o` after two clock edges and does not restart or hold the timers. Once the waits have run out, releasing it lowers `core_rst_o` two edges later, whether it was held since power-on or pulsed while running.
- R10: `run_en_o` is 1 exactly when `core_rst_o` is 0 and no wake-up start-up wait is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; the start-up wait counts its cycles |
| por_pulse_i | input | 1 | Power-on pulse, active high, asynchronous clear of the sequencer |
| brownout_i | input | 1 | Brown-out detect, active high, restarts the sequence |
| mclr_n_i | input | 1 | External master clear, active low, asynchronous |
| wake_req_i | input | 1 | One-cycle wake-up request from sleep |
| osc_rc_i | input | 1 | Oscillator mode: 1 = RC, 0 = crystal-type |
| pwrt_skip_i | input | 1 | 1 = skip the power-up wait after power-on, 0 = run it |
| slow_tick_i | input | 1 | Slow timebase tick that advances the power-up wait |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| run_en_o | output | 1 | Core may execute instructions |

## Verification
A wrong internal state shows up as `core_rst_o` or `run_en_o` changing on the wrong edge. A wait that is skipped or added moves the release by PWRT_TICKS or OST_CYCLES cycles, and an off-by-one count moves it by a single cycle. For this reason the bench counts the exact number of samples for which each output is asserted, not just whether it is eventually released. A lost restart or a timer that is disturbed by master clear shows up as a release that comes too soon or too late after the event, on the first edge where the wrong path is taken.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        SQ_HOLD = 3'd0,  // reset source still active
        SQ_PWRT = 3'd1,  // fixed-duration power-up wait
        SQ_OST  = 3'd2,  // oscillator start-up count under reset
        SQ_WAKE = 3'd3,  // oscillator start-up count after wake-up, no reset
        SQ_RUN  = 3'd4   // sequence complete
    } seq_st_e;

    // What started the current sequence
    typedef enum logic {
        CAUSE_PWRUP = 1'b0,
        CAUSE_BROWN = 1'b1
    } seq_cause_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/seq_sync_chain.sv
module seq_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d_i;
        end else begin : g_multi
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/seq_wait_counter.sv
module seq_wait_counter #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk_i,
    input  logic arst_i,
    input  logic clr_i,
    input  logic adv_i,
    output logic done_o
);
    import rst_seq_pkg::*;

    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } wcnt_s;

    wcnt_s r_d, r_q;

    always_comb begin
        r_d    = r_q;
        done_o = adv_i && (r_q.cnt == LAST);
        if (clr_i)
            r_d.cnt = '0;
        else if (adv_i)
            r_d.cnt = done_o ? '0 : r_q.cnt + W'(1);
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq #(
    parameter int unsigned PWRT_TICKS  = 72,
    parameter int unsigned OST_CYCLES  = 1024,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_pulse_i,
    input  logic brownout_i,
    input  logic mclr_n_i,
    input  logic wake_req_i,
    input  logic osc_rc_i,
    input  logic pwrt_skip_i,
    input  logic slow_tick_i,
    output logic core_rst_o,
    output logic run_en_o
);
    import rst_seq_pkg::*;

    typedef struct packed {
        seq_st_e    st;
        seq_cause_e cause;
    } seq_s;

    seq_s r_d, r_q;
    seq_st_e state_q;

    logic mclr_n_sync;
    logic pwrt_clr, pwrt_adv, pwrt_done;
    logic ost_clr, ost_adv, ost_done;

    // Master clear synchronizer (cleared to "asserted" by power-on)
    seq_sync_chain #(.STAGES(SYNC_STAGES)) u_mclr_sync (
        .clk_i  (clk_i),
        .arst_i (por_pulse_i),
        .d_i    (mclr_n_i),
        .q_o    (mclr_n_sync)
    );

    // Power-up wait, counted in slow ticks
    seq_wait_counter #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
        .clk_i  (clk_i),
        .arst_i (por_pulse_i),
        .clr_i  (pwrt_clr),
        .adv_i  (pwrt_adv),
        .done_o (pwrt_done)
    );

    // Oscillator start-up wait, counted in clock cycles
    seq_wait_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
        .clk_i  (clk_i),
        .arst_i (por_pulse_i),
        .clr_i  (ost_clr),
        .adv_i  (ost_adv),
        .done_o (ost_done)
    );

    assign state_q  = r_q.st;
    assign pwrt_clr = (r_q.st != SQ_PWRT);
    assign pwrt_adv = (r_q.st == SQ_PWRT) && slow_tick_i;
    assign ost_clr  = !((r_q.st == SQ_OST) || (r_q.st == SQ_WAKE));
    assign ost_adv  = !ost_clr;

    always_comb begin
        r_d = r_q;
        if (brownout_i) begin
            r_d.st    = SQ_HOLD;
            r_d.cause = CAUSE_BROWN;
        end else begin
            unique case (r_q.st)
                SQ_HOLD: begin
                    if (r_q.cause == CAUSE_BROWN || !pwrt_skip_i)
                        r_d.st = SQ_PWRT;
                    else if (!osc_rc_i)
                        r_d.st = SQ_OST;
                    else
                        r_d.st = SQ_RUN;
                end
                SQ_PWRT: begin
                    if (pwrt_done)
                        r_d.st = osc_rc_i ? SQ_RUN : SQ_OST;
                end
                SQ_OST, SQ_WAKE: begin
                    if (ost_done)
                        r_d.st = SQ_RUN;
                end
                SQ_RUN: begin
                    if (wake_req_i && !osc_rc_i)
                        r_d.st = SQ_WAKE;
                end
                default: r_d.st = SQ_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk_i or posedge por_pulse_i) begin
        if (por_pulse_i) begin
            r_q.st    <= SQ_HOLD;
            r_q.cause <= CAUSE_PWRUP;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_rst_o = !mclr_n_sync || brownout_i ||
                        (r_q.st == SQ_HOLD) || (r_q.st == SQ_PWRT) || (r_q.st == SQ_OST);
    assign run_en_o   = !core_rst_o && (r_q.st != SQ_WAKE);

endmodule

// File: rtl/rst_timeout_seq_chk.sv
module rst_timeout_seq_chk (
    input logic                 clk,
    input logic                 por_i,
    input logic                 bod_i,
    input logic                 tick_i,
    input logic                 osc_rc_i,
    input logic                 wake_i,
    input logic                 run_en_i,
    input rst_seq_pkg::seq_st_e st_i
);
    import rst_seq_pkg::*;

    AST_WAIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (por_i)
        (st_i == SQ_PWRT && !tick_i && !bod_i) |=> (st_i == SQ_PWRT)); // R5

    AST_RC_SKIPS_OST: assert property (@(posedge clk) disable iff (por_i)
        (st_i == SQ_PWRT && osc_rc_i && !bod_i) |=> (st_i != SQ_OST)); // R3

    AST_OST_ENDS_IN_RUN: assert property (@(posedge clk) disable iff (por_i)
        (st_i == SQ_OST && !bod_i) |=> (st_i == SQ_OST || st_i == SQ_RUN)); // R2

    AST_BROWNOUT_RESTART: assert property (@(posedge clk) disable iff (por_i)
        bod_i |=> (st_i == SQ_HOLD)); // R7

    AST_WAKE_STALLS_RUN: assert property (@(posedge clk) disable iff (por_i)
        (st_i == SQ_RUN && wake_i && !osc_rc_i && !bod_i) |=> !run_en_i); // R8

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (por_i)
        (st_i == SQ_RUN && !wake_i && !bod_i) |=> (st_i == SQ_RUN)); // R9
endmodule

bind rst_timeout_seq rst_timeout_seq_chk u_chk (
    .clk      (clk_i),
    .por_i    (por_pulse_i),
    .bod_i    (brownout_i),
    .tick_i   (slow_tick_i),
    .osc_rc_i (osc_rc_i),
    .wake_i   (wake_req_i),
    .run_en_i (run_en_o),
    .st_i     (state_q)
);

// File: tb/sim_rst_timeout_seq.sv
`timescale 1ns/1ps
module sim_rst_timeout_seq;
    localparam int P = 5;
    localparam int N = 16;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic bod = 1'b0;
    logic mclr_n = 1'b1;
    logic wake = 1'b0;
    logic osc_rc = 1'b0;
    logic skip = 1'b0;
    logic tick = 1'b1;
    logic core_rst, run_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rst_timeout_seq #(.PWRT_TICKS(P), .OST_CYCLES(N), .SYNC_STAGES(2)) u0 (
        .clk_i(clk), .por_pulse_i(por), .brownout_i(bod), .mclr_n_i(mclr_n),
        .wake_req_i(wake), .osc_rc_i(osc_rc), .pwrt_skip_i(skip),
        .slow_tick_i(tick), .core_rst_o(core_rst), .run_en_o(run_en)
    );

    typedef struct packed {
        logic rc;
        logic skp;
        logic brown;
        int   exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b0, P + N},
        '{1'b1, 1'b0, 1'b0, P},
        '{1'b0, 1'b1, 1'b0, N},
        '{1'b1, 1'b1, 1'b0, 1},
        '{1'b0, 1'b1, 1'b1, P + N},
        '{1'b1, 1'b1, 1'b1, P}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2 crystal power-up";
            1: return "R3 RC power-up";
            2: return "R4 crystal skip";
            3: return "R4 RC skip";
            4: return "R6 crystal brown-out";
            default: return "R6 RC brown-out";
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts negedge samples for which the watched output is asserted.
    task automatic measure(input bit use_run, output int n, output int saw_rst);
        n = 0;
        saw_rst = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            wake = 1'b0;
            if (core_rst) saw_rst = 1;
            if (use_run ? !run_en : core_rst) n++;
            else break;
        end
    endtask

    task automatic pulse_por();
        por = 1'b1;
        repeat (3) @(negedge clk);
        por = 1'b0;
    endtask

    task automatic settle();
        repeat (P + N + 6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, sr;
        // R1: reset state while the power-on pulse is high
        repeat (2) @(negedge clk);
        check(int'(core_rst), 1, "R1 core reset during power-on");
        check(int'(run_en), 0, "R1 run enable during power-on");

        // Vector table
        for (int i = 0; i < 6; i++) begin
            osc_rc = VECS[i].rc;
            skip   = VECS[i].skp;
            tick   = 1'b1;
            if (VECS[i].brown) begin
                pulse_por();
                settle();
                bod = 1'b1;
                repeat (3) @(negedge clk);
                check(int'(core_rst), 1, "R1 core reset during brown-out");
                bod = 1'b0;
            end else begin
                pulse_por();
            end
            measure(1'b0, n, sr);
            check(n, VECS[i].exp, vec_tag(i));
        end

        // R5: tick held low stalls the power-up wait
        osc_rc = 1'b0; skip = 1'b0; tick = 1'b0;
        pulse_por();
        repeat (50) @(negedge clk);
        check(int'(core_rst), 1, "R5 no ticks keeps reset");
        tick = 1'b1;
        measure(1'b0, n, sr);
        check(n, P + N - 1, "R5 wait resumes on ticks");

        // R7: brown-out during start-up count restarts the sequence
        pulse_por();
        repeat (P + 5) @(negedge clk);
        bod = 1'b1;
        repeat (3) @(negedge clk);
        bod = 1'b0;
        measure(1'b0, n, sr);
        check(n, P + N, "R7 restart after brown-out");

        // R9: master clear held low through the whole sequence
        mclr_n = 1'b0;
        pulse_por();
        repeat (P + N + 10) @(negedge clk);
        check(int'(core_rst), 1, "R9 master clear holds reset");
        mclr_n = 1'b1;
        measure(1'b0, n, sr);
        check(n, 1, "R9 immediate start on release");

        // R9: master clear pulse while running
        mclr_n = 1'b0;
        repeat (4) @(negedge clk);
        check(int'(core_rst), 1, "R9 master clear pulse asserts reset");
        check(int'(run_en), 0, "R10 run enable low in reset");
        mclr_n = 1'b1;
        measure(1'b0, n, sr);
        check(n, 1, "R9 no timers after master clear");
        check(int'(run_en), 1, "R10 run enable back");

        // R8: wake-up in crystal mode
        wake = 1'b1;
        measure(1'b1, n, sr);
        check(n, N, "R8 wake start-up wait length");
        check(sr, 0, "R8 no core reset during wake");

        // R8: wake-up in RC mode is ignored
        osc_rc = 1'b1;
        @(negedge clk);
        wake = 1'b1;
        measure(1'b1, n, sr);
        check(n, 0, "R8 RC wake ignored");
        check(int'(core_rst), 0, "R8 RC wake keeps reset low");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule